// File: doc/BRIEF.md
# Gate-Scan Clock Output Controller

This block decides, cycle by cycle, what each output of a TFT panel gate driver should be doing. There are two scan clock channels, each with a complementary pair of outputs, and one frame-start output. Each output carries a 2-bit drive code that selects high-impedance, the low rail or the high rail. Each channel also has a charge-share enable. The analog stage behind the block turns these codes into rail-to-rail swings. The frame-start input and the per-channel line clocks come from the timing controller and are sampled by the system clock. A run signal from the start-up sequencer either lets the scan logic drive the outputs or forces every output to a parked code.

Behaviour depends on the frame-start level. While it is high, each clock pair follows its own line clock directly. While it is low, a pair flips its stored polarity on every rising edge of its line clock, holds that polarity while the line clock stays high, and floats with charge sharing on while the line clock is low. The frame-start output looks only at line clock 0.

Top module: `gate_scan_ctrl`

## Requirements
- R1: While the synchronized frame-start level is low and run is high, start_o drives the low rail (2'b01) whatever line clock 0 is.
- R2: While frame-start is high and run is high, start_o drives the high rail (2'b10) if line clock 0 is low and is high-impedance (2'b00) if it is high. Line clock 1 never affects start_o.
- R3: With frame-start low, run high and a channel's line clock low, both outputs of that channel are high-impedance (2'b00) and its share_o bit is 1. share_o is 0 in every other situation.
- R4: With frame-start low, a rising edge on a channel's line clock inverts that channel's stored polarity. The pair then drives ck = high rail if the new polarity is 1, else the low rail.
- R5: With frame-start low and a line clock that stays high, the pair keeps its last driven codes unchanged.
- R6: With frame-start high, ck drives the high rail and ckb the low rail when the line clock is high, and the reverse when it is low. The stored polarity is left unchanged.
- R7: The channels are independent. Each has its own line clock and its own stored polarity.
- R8: Drive codes are 2'b00 high-impedance, 2'b01 low rail and 2'b10 high rail, and 2'b11 never appears. Whenever ck is driven, ckb carries the opposite rail.
- R9: Each input passes through a two-stage synchronizer, and the outputs are registered. A change on an input is seen on the outputs after the third rising clock edge.
- R10: While run_i is low, every ck, ckb and start output carries the parked code (high-impedance if idle_code_i is 2'b00, the low rail for any other value), share_o is 0, and both stored polarities return to 0. The outputs change at the next clock edge, with no synchronizer delay.
- R11: During reset all outputs are high-impedance and share_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Start-up sequencer enable, synchronous |
| idle_code_i | input | 2 | Parked code used while run_i is low |
| frame_start_i | input | 1 | Frame-start level from the timing controller |
| line_clk_i | input | NCH | Line clock per channel |
| ck_o | output | 2*NCH | Drive code of each channel's true output, channel c at bits [2c+1:2c] |
| ckb_o | output | 2*NCH | Drive code of each channel's complement output |
| start_o | output | 2 | Drive code of the frame-start output |
| share_o | output | NCH | Charge-share enable per channel |

## Verification
Two events can land in the same sampled cycle. One is a frame-start transition together with a line-clock rising edge. The other is run falling just as a line clock rises. In the first case the frame-start level decides between direct following and toggling. In the second, the park must win and the stored polarity must clear instead of toggling. The bench has a phase that flips frame-start and both line clocks on the same clock, and another phase that randomizes run alongside the clocks. A behavioural model, built from sample-history queues, predicts every output on every cycle, and each mismatch is reported against the requirement that governs that cycle.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
  localparam logic [1:0] DRV_HIZ = 2'b00;
  localparam logic [1:0] DRV_LO  = 2'b01;
  localparam logic [1:0] DRV_HI  = 2'b10;

  function automatic logic [1:0] drv(input logic hi);
    return hi ? DRV_HI : DRV_LO;
  endfunction

  function automatic logic [1:0] park(input logic lo);
    return lo ? DRV_LO : DRV_HIZ;
  endfunction
endpackage

// File: rtl/gsc_sync.sv
module gsc_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     st_q[s] <= '0;
      else if (s == 0) st_q[s] <= d_i;
      else             st_q[s] <= st_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/gsc_start_out.sv
module gsc_start_out
  import gsc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       idle_lo_i,
  input  logic       stv_i,
  input  logic       line0_i,
  output logic [1:0] start_o
);
  logic [1:0] start_d;

  always_comb begin
    if (!run_i)        start_d = park(idle_lo_i);
    else if (!stv_i)   start_d = DRV_LO;
    else if (line0_i)  start_d = DRV_HIZ;
    else               start_d = DRV_HI;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_o <= DRV_HIZ;
    else         start_o <= start_d;
  end

  a_r1_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !stv_i) |=> start_o == DRV_LO);
  a_r2_start_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && stv_i && line0_i) |=> start_o == DRV_HIZ);
  a_r2_start_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && stv_i && !line0_i) |=> start_o == DRV_HI);
endmodule

// File: rtl/gsc_channel.sv
module gsc_channel
  import gsc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       idle_lo_i,
  input  logic       stv_i,
  input  logic       line_i,
  output logic [1:0] ck_o,
  output logic [1:0] ckb_o,
  output logic       share_o
);
  logic       line_q, rise;
  logic       state_q, state_d;
  logic [1:0] ck_d, ckb_d;
  logic       share_d;

  assign rise = line_i & ~line_q;

  always_comb begin
    state_d = state_q;
    share_d = 1'b0;
    if (!run_i) begin
      state_d = 1'b0;
      ck_d    = park(idle_lo_i);
      ckb_d   = park(idle_lo_i);
    end else if (stv_i) begin
      // direct follow; stored polarity untouched
      ck_d  = drv(line_i);
      ckb_d = drv(!line_i);
    end else if (!line_i) begin
      ck_d    = DRV_HIZ;
      ckb_d   = DRV_HIZ;
      share_d = 1'b1;
    end else begin
      if (rise) state_d = ~state_q;
      ck_d  = drv(state_d);
      ckb_d = drv(!state_d);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= 1'b0;
      state_q <= 1'b0;
      ck_o    <= DRV_HIZ;
      ckb_o   <= DRV_HIZ;
      share_o <= 1'b0;
    end else begin
      line_q  <= line_i;
      state_q <= state_d;
      ck_o    <= ck_d;
      ckb_o   <= ckb_d;
      share_o <= share_d;
    end
  end

  a_r8_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ck_o != 2'b11 && ckb_o != 2'b11);
  a_r8_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && ck_o != DRV_HIZ && $past(run_i)) |-> ckb_o == {ck_o[0], ck_o[1]});
  a_r3_share_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    share_o |-> (ck_o == DRV_HIZ && ckb_o == DRV_HIZ));
  a_r4_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !stv_i && rise) |=> ck_o == drv(!$past(state_q)));
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !stv_i && line_i && !rise && $past(run_i) && !$past(stv_i))
      |=> $stable(ck_o) && $stable(ckb_o));
  a_r6_keep_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && stv_i) |=> $stable(state_q));
endmodule

// File: rtl/gate_scan_ctrl.sv
module gate_scan_ctrl
  import gsc_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [1:0]       idle_code_i,
  input  logic             frame_start_i,
  input  logic [NCH-1:0]   line_clk_i,
  output logic [2*NCH-1:0] ck_o,
  output logic [2*NCH-1:0] ckb_o,
  output logic [1:0]       start_o,
  output logic [NCH-1:0]   share_o
);
  localparam int SW = NCH + 1;

  logic [SW-1:0]  raw, synced;
  logic           stv_s;
  logic [NCH-1:0] line_s;
  logic           idle_lo;

  assign raw     = {line_clk_i, frame_start_i};
  assign stv_s   = synced[0];
  assign line_s  = synced[SW-1:1];
  assign idle_lo = (idle_code_i != DRV_HIZ);

  gsc_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw),
    .q_o    (synced)
  );

  gsc_start_out u_start (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .idle_lo_i (idle_lo),
    .stv_i     (stv_s),
    .line0_i   (line_s[0]),
    .start_o   (start_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    gsc_channel u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run_i),
      .idle_lo_i (idle_lo),
      .stv_i     (stv_s),
      .line_i    (line_s[c]),
      .ck_o      (ck_o[2*c +: 2]),
      .ckb_o     (ckb_o[2*c +: 2]),
      .share_o   (share_o[c])
    );
  end

  a_r10_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (share_o == '0 && start_o != DRV_HI));
  a_r10_park_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && idle_code_i == DRV_HIZ) |=> (ck_o == '0 && ckb_o == '0 && start_o == DRV_HIZ));
endmodule

// File: tb/gate_scan_ctrl_test.sv
module gate_scan_ctrl_test;
  localparam int NCH = 2;
  localparam logic [1:0] HZ = 2'b00, LO = 2'b01, HI = 2'b10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             run = 1'b0;
  logic [1:0]       idle = 2'b00;
  logic             stv = 1'b0;
  logic [NCH-1:0]   line = '0;
  logic [2*NCH-1:0] ck_o, ckb_o;
  logic [1:0]       start_o;
  logic [NCH-1:0]   share_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  gate_scan_ctrl #(.NCH(NCH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .idle_code_i(idle),
    .frame_start_i(stv), .line_clk_i(line),
    .ck_o(ck_o), .ckb_o(ckb_o), .start_o(start_o), .share_o(share_o)
  );

  // reference model: history of sampled inputs, two-edge visibility (R9)
  logic [NCH:0] hist [$];
  logic [1:0]   e_ck [NCH], e_ckb [NCH], e_start;
  logic         e_share [NCH];
  bit           pol [NCH];
  string        t_ck [NCH];
  string        t_start;

  function automatic logic [1:0] rail(input bit h);
    return h ? HI : LO;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {};
      for (int i = 0; i < 3; i++) hist.push_back('0);
      for (int c = 0; c < NCH; c++) begin
        pol[c] = 0; e_ck[c] = HZ; e_ckb[c] = HZ; e_share[c] = 0; t_ck[c] = "R11";
      end
      e_start = HZ; t_start = "R11";
    end else begin
      hist.push_back({line, stv});
      // hist[1]: sampled two edges back, hist[0]: three edges back
      if (!run) begin
        logic [1:0] pk;
        pk = (idle == 2'b00) ? HZ : LO;
        e_start = pk; t_start = "R10";
        for (int c = 0; c < NCH; c++) begin
          pol[c] = 0; e_ck[c] = pk; e_ckb[c] = pk; e_share[c] = 0; t_ck[c] = "R10";
        end
      end else begin
        bit s;
        s = hist[1][0];
        if (!s) begin e_start = LO; t_start = "R1"; end
        else begin e_start = hist[1][1] ? HZ : HI; t_start = "R2"; end
        for (int c = 0; c < NCH; c++) begin
          bit ln, old;
          ln  = hist[1][c+1];
          old = hist[0][c+1];
          e_share[c] = 0;
          if (s) begin
            e_ck[c] = rail(ln); e_ckb[c] = rail(!ln); t_ck[c] = "R6";
          end else if (!ln) begin
            e_ck[c] = HZ; e_ckb[c] = HZ; e_share[c] = 1; t_ck[c] = "R3";
          end else begin
            if (!old) begin pol[c] = !pol[c]; t_ck[c] = "R4 R9"; end
            else t_ck[c] = "R5";
            e_ck[c] = rail(pol[c]); e_ckb[c] = rail(!pol[c]);
          end
          if (c == 1) t_ck[c] = {"R7 ", t_ck[c]};
        end
      end
      void'(hist.pop_front());
    end
  end

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(t_start, start_o, e_start);
    for (int c = 0; c < NCH; c++) begin
      chk(t_ck[c], ck_o[2*c +: 2], e_ck[c]);
      chk("R8 complement", ckb_o[2*c +: 2], e_ckb[c]);
      chk("R3 share", {1'b0, share_o[c]}, {1'b0, e_share[c]});
    end
  endtask

  task automatic step(input int p_line, input int p_stv, input int p_run, input bit together);
    @(negedge clk);
    compare_all();
    if (together) begin
      if ($urandom_range(5) == 0) begin stv = !stv; line = ~line; end
    end else begin
      for (int c = 0; c < NCH; c++)
        if ($urandom_range(p_line - 1) == 0) line[c] = !line[c];
      if (p_stv > 0 && $urandom_range(p_stv - 1) == 0) stv = !stv;
    end
    if (p_run > 0 && $urandom_range(p_run - 1) == 0) begin
      run  = !run;
      idle = 2'($urandom_range(3));
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5ca1));
    // R11: outputs under reset
    repeat (3) @(negedge clk);
    line = '1; stv = 1'b1;
    @(negedge clk);
    chk("R11 ck0", ck_o[1:0], HZ);
    chk("R11 ckb1", ckb_o[3:2], HZ);
    chk("R11 start", start_o, HZ);
    chk("R11 share", {1'b0, share_o[0]}, 2'b00);
    line = '0; stv = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    // R10: parked, high-impedance then low rail
    idle = 2'b00; run = 1'b0;
    repeat (200) step(4, 8, 0, 0);
    idle = 2'b01;
    repeat (200) step(4, 8, 0, 0);
    idle = 2'b11;
    repeat (50) step(4, 8, 0, 0);
    // scanning with frame-start low: toggle/hold/float (R3 R4 R5)
    run = 1'b1; stv = 1'b0;
    repeat (1500) step(4, 0, 0, 0);
    // frame-start changing slowly (R1 R2 R6)
    repeat (800) step(4, 16, 0, 0);
    // frame-start and line edges in the same cycle
    repeat (600) step(1, 0, 0, 1);
    // run toggling against live clocks (R10 with R4)
    repeat (1500) step(3, 12, 40, 0);
    run = 1'b1;
    repeat (10) step(3, 12, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule